// File: doc/BRIEF.md
# Variable Memory Range Type Lookup

This block resolves the memory type of a 36-bit physical address. It holds a set of base/mask register pairs. Each pair describes a naturally aligned region whose size is a power of two, from 4 KiB up to the whole 64 GiB space, and gives that region an 8-bit type code. The block does not interpret type codes. It passes them through unchanged.

Software loads the pairs through an index/data write port. Any write that would set a reserved bit is refused, and so is an unprivileged write to one of the top pairs kept for the operating system. A refused write raises a fault pulse and leaves the register as it was.

The lookup port takes an address together with the result of an external fixed-range lookup. It returns the resolved type one cycle later, with a hit flag and a flag for overlapping variable matches.

Top module: `var_range_typer`

## Requirements
- R1: After reset every pair is invalid. A lookup then returns the default type input, with the hit and overlap outputs low.
- R2: A base write (wrSel=0) takes the region base from data bits 35..12 and the type code from bits 7..0. The region base is that field followed by 12 zero bits.
- R3: A mask write (wrSel=1) takes the enable from data bit 11 and the mask from bits 35..12. An address matches a pair when the pair is enabled and the address agrees with the base on every mask bit set in 35..12. A pair with a cleared enable never matches.
- R4: A base write with any of bits 63..36 or 11..8 set drives wrFault high in the cycle after the write. The base and type of that pair stay unchanged.
- R5: A mask write with any of bits 63..36 or 10..0 set drives wrFault high in the cycle after the write. The mask and enable of that pair stay unchanged.
- R6: The two highest-numbered pairs (6 and 7 by default) accept writes only while wrIsOs is high. Otherwise the write faults and is dropped. Lower pairs accept writes regardless of wrIsOs.
- R7: When fixHit is high, resType equals fixType and resHit is high, whatever the variable pairs match.
- R8: When several pairs match, the lowest-numbered one supplies the type. resOverlap is high when more than one variable pair matches, whatever fixHit is.
- R9: Address bits 35..32 are treated as zero for matching.
- R10: resValid is high exactly in the cycle after a cycle with lkValid high. resType, resHit and resOverlap belong to that lookup.
- R11: When neither the fixed range nor any pair matches, resType equals defType and resHit is low.
- R12: A 4 KiB region (mask bits 35..12 all set) matches only its own page. A mask of all zeros matches every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 = base register, 1 = mask register |
| wrIdx | input | 3 | Pair index |
| wrData | input | 64 | Write data |
| wrIsOs | input | 1 | Write comes from the privileged OS level |
| wrFault | output | 1 | Protection fault, one cycle after a refused write |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 36 | Physical address |
| fixHit | input | 1 | Fixed-range lookup hit |
| fixType | input | 8 | Fixed-range type |
| defType | input | 8 | Type used when nothing matches |
| resValid | output | 1 | Result valid |
| resType | output | 8 | Resolved type |
| resHit | output | 1 | Fixed or variable range matched |
| resOverlap | output | 1 | More than one variable pair matched |

## Verification
A corrupted base, mask or enable bit changes which addresses match. It shows up at the next lookup that lands inside or just outside the affected region: the wrong type appears, or the wrong hit or overlap flag. A write that was refused but took effect anyway is exposed the same way. The lookup right after the fault pulse returns the changed type or region. An error in the priority or latency logic shows within one cycle of the request, as a wrong resType or a misplaced resValid.

// File: rtl/vrt_pkg.sv
package vrt_pkg;
  localparam int ADDR_W = 36;
  localparam int PAGE_W = 12;
  localparam int FLD_W  = ADDR_W - PAGE_W;
  localparam int TYPE_W = 8;
  localparam int DATA_W = 64;
  localparam int IMPL_W = 32;   // implemented physical address bits
  localparam int EN_BIT = 11;   // enable bit in the mask register

  typedef struct packed {
    logic ldBase;
    logic ldMask;
    logic fault;
  } wrStrobe_t;
endpackage

// File: rtl/vrt_ctrl.sv
module vrt_ctrl
  import vrt_pkg::*;
#(
  parameter int NPAIRS   = 8,
  parameter int OS_PAIRS = 2,
  localparam int IDX_W   = $clog2(NPAIRS)
) (
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrIsOs,
  output wrStrobe_t         strb
);
  localparam int OS_LO = NPAIRS - OS_PAIRS;

  logic highBits, baseResv, maskResv, osOnly, refuse;

  always_comb begin
    highBits = |wrData[DATA_W-1:ADDR_W];
    baseResv = highBits | (|wrData[PAGE_W-1:TYPE_W]);
    maskResv = highBits | (|wrData[EN_BIT-1:0]);
    osOnly   = (int'(wrIdx) >= OS_LO);
    refuse   = (wrSel ? maskResv : baseResv) | (osOnly & ~wrIsOs);
    strb.fault  = wrEn & refuse;
    strb.ldBase = wrEn & ~refuse & ~wrSel;
    strb.ldMask = wrEn & ~refuse & wrSel;
  end

  // R6
  always_comb
    os_guard_chk: assert (!(wrEn && osOnly && !wrIsOs) || !(strb.ldBase || strb.ldMask));
endmodule

// File: rtl/vrt_datapath.sv
module vrt_datapath
  import vrt_pkg::*;
#(
  parameter int NPAIRS  = 8,
  localparam int IDX_W  = $clog2(NPAIRS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFault,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              fixHit,
  input  logic [TYPE_W-1:0] fixType,
  input  logic [TYPE_W-1:0] defType,
  output logic              resValid,
  output logic [TYPE_W-1:0] resType,
  output logic              resHit,
  output logic              resOverlap
);
  logic [NPAIRS-1:0][FLD_W-1:0]  baseQ, maskQ;
  logic [NPAIRS-1:0][TYPE_W-1:0] typeQ;
  logic [NPAIRS-1:0]             enQ;
  logic [NPAIRS-1:0]             matchVec;
  logic [FLD_W-1:0]              addrFld;
  logic                          varHit, multiHit;
  logic [TYPE_W-1:0]             varType;

  // unimplemented address bits are forced to zero
  assign addrFld = {{(ADDR_W-IMPL_W){1'b0}}, lkAddr[IMPL_W-1:PAGE_W]};

  for (genvar i = 0; i < NPAIRS; i++) begin : g_pair
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ[i] <= '0;
        typeQ[i] <= '0;
        maskQ[i] <= '0;
        enQ[i]   <= 1'b0;
      end else if (int'(wrIdx) == i) begin
        if (strb.ldBase) begin
          baseQ[i] <= wrData[ADDR_W-1:PAGE_W];
          typeQ[i] <= wrData[TYPE_W-1:0];
        end
        if (strb.ldMask) begin
          maskQ[i] <= wrData[ADDR_W-1:PAGE_W];
          enQ[i]   <= wrData[EN_BIT];
        end
      end
    end
    assign matchVec[i] = enQ[i] && (((addrFld ^ baseQ[i]) & maskQ[i]) == '0);
  end

  always_comb begin
    varHit  = 1'b0;
    varType = '0;
    for (int i = NPAIRS - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        varHit  = 1'b1;
        varType = typeQ[i];
      end
    end
    multiHit = ($countones(matchVec) > 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrFault    <= 1'b0;
      resValid   <= 1'b0;
      resType    <= '0;
      resHit     <= 1'b0;
      resOverlap <= 1'b0;
    end else begin
      wrFault  <= strb.fault;
      resValid <= lkValid;
      if (lkValid) begin
        resType    <= fixHit ? fixType : (varHit ? varType : defType);
        resHit     <= fixHit | varHit;
        resOverlap <= multiHit;
      end
    end
  end

  // R4
  base_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrFault |-> (baseQ == $past(baseQ)) && (typeQ == $past(typeQ)));
  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrFault |-> (maskQ == $past(maskQ)) && (enQ == $past(enQ)));
  // R10
  res_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> resValid);
  // R7
  fix_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && fixHit) |=> (resHit && resType == $past(fixType)));
  // R11
  miss_default_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resHit) |-> (resType == $past(defType)));
  // R8
  overlap_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resOverlap) |-> resHit);
endmodule

// File: rtl/var_range_typer.sv
module var_range_typer
  import vrt_pkg::*;
#(
  parameter int NPAIRS   = 8,
  parameter int OS_PAIRS = 2,
  localparam int IDX_W   = $clog2(NPAIRS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrIsOs,
  output logic              wrFault,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              fixHit,
  input  logic [TYPE_W-1:0] fixType,
  input  logic [TYPE_W-1:0] defType,
  output logic              resValid,
  output logic [TYPE_W-1:0] resType,
  output logic              resHit,
  output logic              resOverlap
);
  wrStrobe_t strb;

  vrt_ctrl #(.NPAIRS(NPAIRS), .OS_PAIRS(OS_PAIRS)) u_ctrl (
    .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx), .wrData(wrData),
    .wrIsOs(wrIsOs), .strb(strb)
  );

  vrt_datapath #(.NPAIRS(NPAIRS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .wrData(wrData),
    .wrFault(wrFault), .lkValid(lkValid), .lkAddr(lkAddr), .fixHit(fixHit),
    .fixType(fixType), .defType(defType), .resValid(resValid),
    .resType(resType), .resHit(resHit), .resOverlap(resOverlap)
  );
endmodule

// File: tb/var_range_typer_tb.sv
`timescale 1ns/1ps
module var_range_typer_tb;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        wrEn = 1'b0, wrSel = 1'b0, wrIsOs = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [63:0] wrData = '0;
  logic        lkValid = 1'b0, fixHit = 1'b0;
  logic [35:0] lkAddr = '0;
  logic [7:0]  fixType = '0, defType = 8'h0A;
  logic        wrFault, resValid, resHit, resOverlap;
  logic [7:0]  resType;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  var_range_typer u_dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mkMask(int lg);
    logic [63:0] m = 64'h800;
    for (int b = 12; b < 36; b++) if (b >= lg) m[b] = 1'b1;
    return m;
  endfunction

  task automatic writeReg(logic sel, int idx, logic [63:0] d, logic os,
                          logic expFault, string tag);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrIdx = 3'(idx); wrData = d; wrIsOs = os;
    @(negedge clk);
    wrEn = 1'b0;
    chk({tag, " fault"}, 64'(wrFault), 64'(expFault));
  endtask

  task automatic lookup(logic [35:0] a, logic fh, logic [7:0] ft, logic [7:0] expT,
                        logic expH, logic expO, string tag);
    @(negedge clk);
    lkValid = 1'b1; lkAddr = a; fixHit = fh; fixType = ft;
    @(negedge clk);
    lkValid = 1'b0; fixHit = 1'b0;
    chk({tag, " valid"}, 64'(resValid), 64'd1);
    chk({tag, " type"}, 64'(resType), 64'(expT));
    chk({tag, " hit"}, 64'(resHit), 64'(expH));
    chk({tag, " overlap"}, 64'(resOverlap), 64'(expO));
  endtask

  task automatic t_reset;
    lookup(36'h0_0010_5000, 0, 0, 8'h0A, 0, 0, "R1 reset");
  endtask

  task automatic t_basic;
    writeReg(0, 0, 64'h0010_0006, 1, 0, "R2 base0");
    writeReg(1, 0, mkMask(20), 1, 0, "R3 mask0");
    lookup(36'h0_0010_5000, 0, 0, 8'h06, 1, 0, "R2 hit in 1MB");
    lookup(36'h0_0020_0000, 0, 0, 8'h0A, 0, 0, "R11 miss default");
  endtask

  task automatic t_page;
    writeReg(0, 1, 64'h4000_0004, 1, 0, "R12 base1");
    writeReg(1, 1, mkMask(12), 1, 0, "R12 mask1");
    lookup(36'h0_4000_0FFF, 0, 0, 8'h04, 1, 0, "R12 page end");
    lookup(36'h0_4000_1000, 0, 0, 8'h0A, 0, 0, "R12 next page");
    writeReg(1, 1, mkMask(12) & ~64'h800, 1, 0, "R3 disable1");
    lookup(36'h0_4000_0000, 0, 0, 8'h0A, 0, 0, "R3 disabled miss");
  endtask

  task automatic t_upper;
    lookup(36'hF_0010_5000, 0, 0, 8'h06, 1, 0, "R9 upper ignored");
  endtask

  task automatic t_overlap;
    writeReg(0, 2, 64'h0000_0001, 0, 0, "R8 base2");
    writeReg(1, 2, mkMask(24), 0, 0, "R8 mask2");
    lookup(36'h0_0010_5000, 0, 0, 8'h06, 1, 1, "R8 lowest wins");
    lookup(36'h0_0000_1000, 0, 0, 8'h01, 1, 0, "R8 single match");
    lookup(36'h0_0010_5000, 1, 8'h05, 8'h05, 1, 1, "R7 fixed wins");
    lookup(36'h0_0300_0000, 1, 8'h03, 8'h03, 1, 0, "R7 fixed alone");
  endtask

  task automatic t_faults;
    writeReg(0, 0, 64'h0010_0207, 1, 1, "R4 bit9");
    writeReg(0, 0, 64'h100_0010_0007, 1, 1, "R4 bit40");
    writeReg(1, 0, mkMask(12) | 64'h8, 1, 1, "R5 bit3");
    writeReg(1, 0, mkMask(12) | (64'h1 << 50), 1, 1, "R5 bit50");
    lookup(36'h0_0010_5000, 0, 0, 8'h06, 1, 1, "R4 R5 unchanged");
  endtask

  task automatic t_os;
    writeReg(0, 7, 64'h8000_0002, 0, 1, "R6 user base7");
    writeReg(1, 7, mkMask(12), 1, 0, "R6 os mask7");
    lookup(36'h0_8000_0000, 0, 0, 8'h0A, 0, 0, "R6 base7 blocked");
    writeReg(0, 7, 64'h8000_0002, 1, 0, "R6 os base7");
    lookup(36'h0_8000_0000, 0, 0, 8'h02, 1, 0, "R6 base7 loaded");
    writeReg(1, 6, 64'h0, 0, 1, "R6 user mask6");
    writeReg(1, 5, 64'h0, 0, 0, "R6 user pair5 ok");
  endtask

  task automatic t_whole;
    writeReg(0, 5, 64'h0000_0009, 0, 0, "R12 base5");
    writeReg(1, 5, 64'h800, 0, 0, "R12 whole mask5");
    lookup(36'h0_C000_0000, 0, 0, 8'h09, 1, 0, "R12 whole space");
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R10 idle no valid", 64'(resValid), 64'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 reset fault", 64'(wrFault), 64'd0);
    chk("R10 reset valid", 64'(resValid), 64'd0);
    t_reset();
    t_basic();
    t_page();
    t_upper();
    t_overlap();
    t_faults();
    t_os();
    t_idle();
    t_whole();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule